// File: doc/BRIEF.md
# Message and Doorbell Interrupt Unit

This block is a register-mapped mailbox between a host bus master and a local processor. Each side reaches it through its own request port: a single-cycle request with a write flag, a byte offset and write data. The offset must be aligned to a 32-bit word. Read data comes back registered in the cycle after the request. Both ports see the same register file. Which registers a side may read or write depends on the direction of the traffic: the host posts inbound messages and inbound doorbells, and the local processor posts outbound ones.

A posted message or a nonzero doorbell sets a sticky status bit on the receiving side. Reading a doorbell hands back its value and empties it. Reading a status register hands back the status filtered by that side's enable mask and clears the status. Four status inputs from an external queue engine also set sticky bits. Each side has one registered, active-high interrupt line. That line is high when any enabled status bit is set.

Top module: `mbox_unit`

## Requirements
- R1: The host writes inbound message 0 and 1 at offsets 0x50 and 0x54, and the local side writes outbound message 0 and 1 at 0x58 and 0x5C. Either side can read all four message registers, and the read data appears in the cycle after the request.
- R2: A host write to inbound message n sets inbound status bit n. A local write to outbound message n sets outbound status bit n.
- R3: A doorbell write ORs its data into the doorbell. The host writes the inbound doorbell at 0x68 and the local side reads it there. The local side writes the outbound doorbell at 0x60 and the host reads it there. A doorbell read returns the current content and empties it. Bits written in the same cycle as that read are kept.
- R4: Inbound doorbell bit 31 is the machine-check request and bits 30:0 are ordinary doorbell bits. Nonzero ordinary bits set inbound status bit 3, and bit 31 sets inbound status bit 4. A nonzero outbound doorbell sets outbound status bit 3.
- R5: A status read returns status AND mask and clears the whole status register. The host reads outbound status at 0x30 and the local side reads inbound status at 0x100. A bit set in the same cycle as the clearing read stays set.
- R6: The host reads and writes the outbound mask at 0x34, and the local side reads and writes the inbound mask at 0x104. A 1 enables a bit. Only implemented bits are stored: outbound bits 0, 1, 3 and 5, and inbound bits 0, 1, 3, 4, 5, 7 and 8. Every other bit reads 0.
- R7: Queue inputs set sticky status bits while they are high. The outbound post-queue-not-empty input sets outbound bit 5. The inbound post-queue-not-empty input sets inbound bit 5, inbound post-queue overflow sets bit 7, and inbound free-queue overflow sets bit 8.
- R8: `hostIrq` and `localIrq` are registered. Each is high one cycle after its side's status AND mask is nonzero.
- R9: Writes to registers the side may not write, and writes to unmapped offsets, change nothing. Reads of registers the side may not read, and reads of unmapped offsets, return 0 and clear nothing.
- R10: After reset every register, both read data outputs and both interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hReq | input | 1 | Host access request |
| hWr | input | 1 | Host write (1) or read (0) |
| hAddr | input | 12 | Host byte offset |
| hWdata | input | 32 | Host write data |
| hRdata | output | 32 | Host read data, valid in the cycle after the request |
| lReq | input | 1 | Local access request |
| lWr | input | 1 | Local write (1) or read (0) |
| lAddr | input | 12 | Local byte offset |
| lWdata | input | 32 | Local write data |
| lRdata | output | 32 | Local read data, valid in the cycle after the request |
| outPostNe | input | 1 | Outbound post queue not empty |
| inPostNe | input | 1 | Inbound post queue not empty |
| inPostOvf | input | 1 | Inbound post queue overflow |
| inFreeOvf | input | 1 | Inbound free queue overflow |
| hostIrq | output | 1 | Interrupt toward the host |
| localIrq | output | 1 | Interrupt toward the local processor |

## Verification
Messages are posted with distinct values to each index so that a swapped index or a wrong status bit shows up in the data. Doorbell patterns are posted in two writes with disjoint bits, so the read value shows whether bits were ORed or overwritten. The machine-check bit is posted alone, which separates status bit 4 from bit 3. Reads and posts are issued in the same cycle on the two ports to show that a clearing read loses neither a new doorbell bit nor a new status bit. Mask writes of all ones, disallowed writes and disallowed reads separate the implemented bits from the reserved ones and show where access is refused.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 12;
  localparam int MSG_CNT   = 2;   // message bits occupy status bits 0..MSG_CNT-1
  localparam int MSG_IDX_W = (MSG_CNT > 1) ? $clog2(MSG_CNT) : 1;
  localparam int MSG_STEP  = DATA_W / 8;

  // register offsets (byte addresses, word aligned)
  localparam logic [ADDR_W-1:0] OFS_OUT_STAT = ADDR_W'('h030);
  localparam logic [ADDR_W-1:0] OFS_OUT_MASK = ADDR_W'('h034);
  localparam logic [ADDR_W-1:0] OFS_IN_MSG   = ADDR_W'('h050);
  localparam logic [ADDR_W-1:0] OFS_OUT_MSG  = ADDR_W'('h058);
  localparam logic [ADDR_W-1:0] OFS_OUT_DB   = ADDR_W'('h060);
  localparam logic [ADDR_W-1:0] OFS_IN_DB    = ADDR_W'('h068);
  localparam logic [ADDR_W-1:0] OFS_IN_STAT  = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] OFS_IN_MASK  = ADDR_W'('h104);

  // status bit positions
  localparam int BIT_DB   = 3;
  localparam int BIT_MC   = 4;
  localparam int BIT_PNE  = 5;
  localparam int BIT_POVF = 7;
  localparam int BIT_FOVF = 8;

  // machine-check request bit inside the inbound doorbell
  localparam int MC_DB_BIT = DATA_W - 1;

  localparam logic [DATA_W-1:0] MSG_BITS = DATA_W'((1 << MSG_CNT) - 1);
  localparam logic [DATA_W-1:0] OUT_IMPL = MSG_BITS
                                         | DATA_W'(1 << BIT_DB)
                                         | DATA_W'(1 << BIT_PNE);
  localparam logic [DATA_W-1:0] IN_IMPL  = MSG_BITS
                                         | DATA_W'(1 << BIT_DB)
                                         | DATA_W'(1 << BIT_MC)
                                         | DATA_W'(1 << BIT_PNE)
                                         | DATA_W'(1 << BIT_POVF)
                                         | DATA_W'(1 << BIT_FOVF);

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_IN_MSG,
    SEL_OUT_MSG,
    SEL_OUT_DB,
    SEL_IN_DB,
    SEL_OUT_STAT,
    SEL_OUT_MASK,
    SEL_IN_STAT,
    SEL_IN_MASK
  } rdSel_e;

  typedef struct packed {
    logic [MSG_CNT-1:0]   wrInMsg;
    logic [MSG_CNT-1:0]   wrOutMsg;
    logic                 wrInDb;
    logic                 wrOutDb;
    logic                 wrOutMask;
    logic                 wrInMask;
    logic                 clrOutDb;
    logic                 clrOutStat;
    logic                 clrInDb;
    logic                 clrInStat;
    rdSel_e               hostSel;
    logic [MSG_IDX_W-1:0] hostIdx;
    rdSel_e               locSel;
    logic [MSG_IDX_W-1:0] locIdx;
  } strobe_t;

endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic              hReq,
  input  logic              hWr,
  input  logic [ADDR_W-1:0] hAddr,
  input  logic              lReq,
  input  logic              lWr,
  input  logic [ADDR_W-1:0] lAddr,
  output strobe_t           stb
);

  function automatic logic [ADDR_W-1:0] msgOfs(logic [ADDR_W-1:0] base, int m);
    return base + ADDR_W'(m * MSG_STEP);
  endfunction

  logic hRd, hWt, lRd, lWt;
  assign hRd = hReq && !hWr;
  assign hWt = hReq &&  hWr;
  assign lRd = lReq && !lWr;
  assign lWt = lReq &&  lWr;

  always_comb begin
    stb = '0;
    // message registers: host posts inbound, local posts outbound, both read all
    for (int m = 0; m < MSG_CNT; m++) begin
      stb.wrInMsg[m]  = hWt && (hAddr == msgOfs(OFS_IN_MSG, m));
      stb.wrOutMsg[m] = lWt && (lAddr == msgOfs(OFS_OUT_MSG, m));
      if (hRd && hAddr == msgOfs(OFS_IN_MSG, m)) begin
        stb.hostSel = SEL_IN_MSG;
        stb.hostIdx = MSG_IDX_W'(m);
      end
      if (hRd && hAddr == msgOfs(OFS_OUT_MSG, m)) begin
        stb.hostSel = SEL_OUT_MSG;
        stb.hostIdx = MSG_IDX_W'(m);
      end
      if (lRd && lAddr == msgOfs(OFS_IN_MSG, m)) begin
        stb.locSel = SEL_IN_MSG;
        stb.locIdx = MSG_IDX_W'(m);
      end
      if (lRd && lAddr == msgOfs(OFS_OUT_MSG, m)) begin
        stb.locSel = SEL_OUT_MSG;
        stb.locIdx = MSG_IDX_W'(m);
      end
    end

    stb.wrInDb    = hWt && (hAddr == OFS_IN_DB);
    stb.wrOutMask = hWt && (hAddr == OFS_OUT_MASK);
    stb.wrOutDb   = lWt && (lAddr == OFS_OUT_DB);
    stb.wrInMask  = lWt && (lAddr == OFS_IN_MASK);

    if (hRd) begin
      case (hAddr)
        OFS_OUT_DB: begin
          stb.hostSel  = SEL_OUT_DB;
          stb.clrOutDb = 1'b1;
        end
        OFS_OUT_STAT: begin
          stb.hostSel    = SEL_OUT_STAT;
          stb.clrOutStat = 1'b1;
        end
        OFS_OUT_MASK: stb.hostSel = SEL_OUT_MASK;
        default: ;
      endcase
    end

    if (lRd) begin
      case (lAddr)
        OFS_IN_DB: begin
          stb.locSel  = SEL_IN_DB;
          stb.clrInDb = 1'b1;
        end
        OFS_IN_STAT: begin
          stb.locSel    = SEL_IN_STAT;
          stb.clrInStat = 1'b1;
        end
        OFS_IN_MASK: stb.locSel = SEL_IN_MASK;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] hWdata,
  input  logic [DATA_W-1:0] lWdata,
  input  logic              outPostNe,
  input  logic              inPostNe,
  input  logic              inPostOvf,
  input  logic              inFreeOvf,
  output logic [DATA_W-1:0] hRdata,
  output logic [DATA_W-1:0] lRdata,
  output logic              hostIrq,
  output logic              localIrq,
  output logic [DATA_W-1:0] outStat,
  output logic [DATA_W-1:0] inStat,
  output logic [DATA_W-1:0] outMask,
  output logic [DATA_W-1:0] inMask,
  output logic [DATA_W-1:0] outDb,
  output logic [DATA_W-1:0] inDb,
  output logic [DATA_W-1:0] inMsgLow
);

  logic [MSG_CNT-1:0][DATA_W-1:0] inMsg;
  logic [MSG_CNT-1:0][DATA_W-1:0] outMsg;

  logic [DATA_W-1:0] outSet, inSet;
  logic [DATA_W-1:0] outStatNext, inStatNext;
  logic [DATA_W-1:0] outDbNext, inDbNext;

  assign inMsgLow = inMsg[0];

  // sticky set sources, one per status bit
  always_comb begin
    outSet = '0;
    inSet  = '0;
    for (int m = 0; m < MSG_CNT; m++) begin
      outSet[m] = stb.wrOutMsg[m];
      inSet[m]  = stb.wrInMsg[m];
    end
    outSet[BIT_DB]  = |outDb;
    outSet[BIT_PNE] = outPostNe;
    inSet[BIT_DB]   = |inDb[MC_DB_BIT-1:0];
    inSet[BIT_MC]   = inDb[MC_DB_BIT];
    inSet[BIT_PNE]  = inPostNe;
    inSet[BIT_POVF] = inPostOvf;
    inSet[BIT_FOVF] = inFreeOvf;
  end

  // clearing read first, new events on top so none is lost
  assign outStatNext = ((stb.clrOutStat ? '0 : outStat) | outSet) & OUT_IMPL;
  assign inStatNext  = ((stb.clrInStat  ? '0 : inStat)  | inSet)  & IN_IMPL;
  assign outDbNext   = (stb.clrOutDb ? '0 : outDb) | (stb.wrOutDb ? lWdata : '0);
  assign inDbNext    = (stb.clrInDb  ? '0 : inDb)  | (stb.wrInDb  ? hWdata : '0);

  function automatic logic [DATA_W-1:0] pick(rdSel_e sel, logic [MSG_IDX_W-1:0] idx);
    case (sel)
      SEL_IN_MSG:   return inMsg[idx];
      SEL_OUT_MSG:  return outMsg[idx];
      SEL_OUT_DB:   return outDb;
      SEL_IN_DB:    return inDb;
      SEL_OUT_STAT: return outStat & outMask;
      SEL_OUT_MASK: return outMask;
      SEL_IN_STAT:  return inStat & inMask;
      SEL_IN_MASK:  return inMask;
      default:      return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inMsg    <= '0;
      outMsg   <= '0;
      outStat  <= '0;
      inStat   <= '0;
      outMask  <= '0;
      inMask   <= '0;
      outDb    <= '0;
      inDb     <= '0;
      hRdata   <= '0;
      lRdata   <= '0;
      hostIrq  <= 1'b0;
      localIrq <= 1'b0;
    end else begin
      for (int m = 0; m < MSG_CNT; m++) begin
        if (stb.wrInMsg[m])  inMsg[m]  <= hWdata;
        if (stb.wrOutMsg[m]) outMsg[m] <= lWdata;
      end
      if (stb.wrOutMask) outMask <= hWdata & OUT_IMPL;
      if (stb.wrInMask)  inMask  <= lWdata & IN_IMPL;
      outStat  <= outStatNext;
      inStat   <= inStatNext;
      outDb    <= outDbNext;
      inDb     <= inDbNext;
      hRdata   <= pick(stb.hostSel, stb.hostIdx);
      lRdata   <= pick(stb.locSel, stb.locIdx);
      hostIrq  <= |(outStat & outMask);
      localIrq <= |(inStat & inMask);
    end
  end

endmodule

// File: rtl/mbox_unit.sv
module mbox_unit
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hReq,
  input  logic              hWr,
  input  logic [ADDR_W-1:0] hAddr,
  input  logic [DATA_W-1:0] hWdata,
  output logic [DATA_W-1:0] hRdata,
  input  logic              lReq,
  input  logic              lWr,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWdata,
  output logic [DATA_W-1:0] lRdata,
  input  logic              outPostNe,
  input  logic              inPostNe,
  input  logic              inPostOvf,
  input  logic              inFreeOvf,
  output logic              hostIrq,
  output logic              localIrq
);

  strobe_t           stb;
  logic [DATA_W-1:0] outStat, inStat, outMask, inMask, outDb, inDb, inMsgLow;

  mbox_ctrl u_ctrl (
    .hReq  (hReq),
    .hWr   (hWr),
    .hAddr (hAddr),
    .lReq  (lReq),
    .lWr   (lWr),
    .lAddr (lAddr),
    .stb   (stb)
  );

  mbox_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .hWdata    (hWdata),
    .lWdata    (lWdata),
    .outPostNe (outPostNe),
    .inPostNe  (inPostNe),
    .inPostOvf (inPostOvf),
    .inFreeOvf (inFreeOvf),
    .hRdata    (hRdata),
    .lRdata    (lRdata),
    .hostIrq   (hostIrq),
    .localIrq  (localIrq),
    .outStat   (outStat),
    .inStat    (inStat),
    .outMask   (outMask),
    .inMask    (inMask),
    .outDb     (outDb),
    .inDb      (inDb),
    .inMsgLow  (inMsgLow)
  );

endmodule

// File: rtl/mbox_unit_chk.sv
module mbox_unit_chk
  import mbox_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              hReq,
  input logic              hWr,
  input logic [ADDR_W-1:0] hAddr,
  input logic [DATA_W-1:0] hRdata,
  input logic              lReq,
  input logic              lWr,
  input logic [ADDR_W-1:0] lAddr,
  input logic              localIrq,
  input logic [DATA_W-1:0] outStat,
  input logic [DATA_W-1:0] inStat,
  input logic [DATA_W-1:0] inMask,
  input logic [DATA_W-1:0] outDb,
  input logic [DATA_W-1:0] inMsgLow
);

  AST_OUT_MSG_SETS_STAT: assert property (@(posedge clk) disable iff (!rstN)
    (lReq && lWr && lAddr == OFS_OUT_MSG) |=> outStat[0]); // R2

  AST_DB_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (hReq && !hWr && hAddr == OFS_OUT_DB && !(lReq && lWr && lAddr == OFS_OUT_DB))
    |=> (outDb == '0)); // R3

  AST_RESERVED_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((outStat & ~OUT_IMPL) == '0) && ((inStat & ~IN_IMPL) == '0)); // R6

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    localIrq |-> ($past(inMask) != '0)); // R8

  AST_FORBIDDEN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (lReq && lWr && lAddr == OFS_IN_MSG && !(hReq && hWr && hAddr == OFS_IN_MSG))
    |=> $stable(inMsgLow)); // R9

  AST_FORBIDDEN_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (hReq && !hWr && hAddr == OFS_IN_DB) |=> (hRdata == '0)); // R9

endmodule

bind mbox_unit mbox_unit_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hReq     (hReq),
  .hWr      (hWr),
  .hAddr    (hAddr),
  .hRdata   (hRdata),
  .lReq     (lReq),
  .lWr      (lWr),
  .lAddr    (lAddr),
  .localIrq (localIrq),
  .outStat  (outStat),
  .inStat   (inStat),
  .inMask   (inMask),
  .outDb    (outDb),
  .inMsgLow (inMsgLow)
);

// File: tb/mbox_unit_tb.sv
module mbox_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        hReq, hWr, lReq, lWr;
  logic [11:0] hAddr, lAddr;
  logic [31:0] hWdata, lWdata, hRdata, lRdata;
  logic        outPostNe, inPostNe, inPostOvf, inFreeOvf;
  logic        hostIrq, localIrq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mbox_unit u_dut (
    .clk(clk), .rstN(rstN),
    .hReq(hReq), .hWr(hWr), .hAddr(hAddr), .hWdata(hWdata), .hRdata(hRdata),
    .lReq(lReq), .lWr(lWr), .lAddr(lAddr), .lWdata(lWdata), .lRdata(lRdata),
    .outPostNe(outPostNe), .inPostNe(inPostNe), .inPostOvf(inPostOvf), .inFreeOvf(inFreeOvf),
    .hostIrq(hostIrq), .localIrq(localIrq)
  );

  task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hw(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    hReq = 1; hWr = 1; hAddr = a; hWdata = d;
    @(negedge clk);
    hReq = 0; hWr = 0;
  endtask

  task automatic hr(input logic [11:0] a, output logic [31:0] q);
    @(negedge clk);
    hReq = 1; hWr = 0; hAddr = a;
    @(negedge clk);
    hReq = 0;
    q = hRdata;
  endtask

  task automatic lw(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    lReq = 1; lWr = 1; lAddr = a; lWdata = d;
    @(negedge clk);
    lReq = 0; lWr = 0;
  endtask

  task automatic lr(input logic [11:0] a, output logic [31:0] q);
    @(negedge clk);
    lReq = 1; lWr = 0; lAddr = a;
    @(negedge clk);
    lReq = 0;
    q = lRdata;
  endtask

  // one access on each port in the same cycle
  task automatic both(input logic hw_, input logic [11:0] ha, input logic [31:0] hd,
                      input logic lw_, input logic [11:0] la, input logic [31:0] ld,
                      output logic [31:0] hq, output logic [31:0] lq);
    @(negedge clk);
    hReq = 1; hWr = hw_; hAddr = ha; hWdata = hd;
    lReq = 1; lWr = lw_; lAddr = la; lWdata = ld;
    @(negedge clk);
    hReq = 0; hWr = 0; lReq = 0; lWr = 0;
    hq = hRdata; lq = lRdata;
  endtask

  task automatic clearStatus();
    logic [31:0] q;
    hr(12'h030, q);
    lr(12'h100, q);
    idle(1);
  endtask

  task automatic t_reset();
    logic [31:0] q;
    expect32("R10 hostIrq", {31'b0, hostIrq}, 0);
    expect32("R10 localIrq", {31'b0, localIrq}, 0);
    expect32("R10 hRdata", hRdata, 0);
    expect32("R10 lRdata", lRdata, 0);
    lr(12'h050, q); expect32("R10 in msg0", q, 0);
    lr(12'h104, q); expect32("R10 in mask", q, 0);
    hr(12'h060, q); expect32("R10 out db", q, 0);
  endtask

  task automatic t_messages();
    logic [31:0] q;
    hw(12'h050, 32'hA0A0_0001);
    hw(12'h054, 32'hB0B0_0002);
    lr(12'h050, q); expect32("R1 in msg0", q, 32'hA0A0_0001);
    lr(12'h054, q); expect32("R1 in msg1", q, 32'hB0B0_0002);
    lw(12'h104, 32'h3);
    lr(12'h100, q); expect32("R2 in status msgs", q, 32'h3);
    lr(12'h100, q); expect32("R5 in status cleared", q, 0);
    lw(12'h058, 32'hC0C0_0003);
    lw(12'h05C, 32'hD0D0_0004);
    hr(12'h058, q); expect32("R1 out msg0", q, 32'hC0C0_0003);
    hr(12'h05C, q); expect32("R1 out msg1", q, 32'hD0D0_0004);
    hw(12'h034, 32'h1);
    hr(12'h030, q); expect32("R5 out status masked", q, 32'h1);
    hw(12'h034, 32'h2);
    hr(12'h030, q); expect32("R5 out status cleared by read", q, 0);
  endtask

  task automatic t_doorbells();
    logic [31:0] q, lq;
    clearStatus();
    lw(12'h104, 32'h1BB);
    hw(12'h034, 32'h2B);
    clearStatus();
    hw(12'h068, 32'h5);
    hw(12'h068, 32'h8);
    lr(12'h068, q); expect32("R3 in db ORed", q, 32'hD);
    lr(12'h068, q); expect32("R3 in db emptied", q, 0);
    lr(12'h100, q); expect32("R4 in status db bit", q, 32'h8);
    lr(12'h100, q); expect32("R5 in status cleared", q, 0);
    hw(12'h068, 32'h8000_0000);
    lr(12'h068, q); expect32("R4 machine check db", q, 32'h8000_0000);
    lr(12'h100, q); expect32("R4 machine check status bit4", q, 32'h10);
    lr(12'h100, q); expect32("R4 machine check cleared", q, 0);
    lw(12'h060, 32'h3);
    hr(12'h060, q); expect32("R3 out db", q, 32'h3);
    hr(12'h030, q); expect32("R4 out status db bit", q, 32'h8);
    hr(12'h030, q); expect32("R4 out status cleared", q, 0);
    lw(12'h060, 32'h1);
    both(1'b0, 12'h060, 0, 1'b1, 12'h060, 32'h40, q, lq);
    expect32("R3 read returns old db", q, 32'h1);
    hr(12'h060, q); expect32("R3 same-cycle write kept", q, 32'h40);
    clearStatus();
  endtask

  task automatic t_status_race();
    logic [31:0] q, hq;
    clearStatus();
    lr(12'h100, q); expect32("R5 status empty before race", q, 0);
    both(1'b1, 12'h050, 32'h1111_0000, 1'b0, 12'h100, 0, hq, q);
    expect32("R5 read during set", q, 0);
    lr(12'h100, q); expect32("R5 same-cycle set kept", q, 32'h1);
  endtask

  task automatic t_irq();
    logic [31:0] q;
    clearStatus();
    expect32("R8 localIrq idle", {31'b0, localIrq}, 0);
    hw(12'h054, 32'h2222_0000);
    expect32("R8 localIrq lags one cycle", {31'b0, localIrq}, 0);
    idle(1);
    expect32("R8 localIrq raised", {31'b0, localIrq}, 1);
    lr(12'h100, q);
    idle(1);
    expect32("R8 localIrq dropped after clear", {31'b0, localIrq}, 0);
    lw(12'h104, 32'h0);
    hw(12'h050, 32'h3333_0000);
    idle(2);
    expect32("R8 masked no irq", {31'b0, localIrq}, 0);
    lw(12'h104, 32'h1);
    idle(1);
    expect32("R8 irq after enable", {31'b0, localIrq}, 1);
    lw(12'h104, 32'h1BB);
    clearStatus();
    lw(12'h058, 32'h4444_0000);
    idle(1);
    expect32("R8 hostIrq raised", {31'b0, hostIrq}, 1);
    hr(12'h030, q);
    idle(1);
    expect32("R8 hostIrq dropped", {31'b0, hostIrq}, 0);
  endtask

  task automatic t_queue();
    logic [31:0] q;
    clearStatus();
    @(negedge clk); outPostNe = 1;
    @(negedge clk); outPostNe = 0;
    hr(12'h030, q); expect32("R7 out post not empty", q, 32'h20);
    @(negedge clk); inPostNe = 1; inPostOvf = 1; inFreeOvf = 1;
    @(negedge clk); inPostNe = 0; inPostOvf = 0; inFreeOvf = 0;
    lr(12'h100, q); expect32("R7 inbound queue bits", q, 32'h1A0);
    lr(12'h100, q); expect32("R7 queue bits sticky until read", q, 0);
  endtask

  task automatic t_masks_access();
    logic [31:0] q;
    hw(12'h034, 32'hFFFF_FFFF);
    hr(12'h034, q); expect32("R6 out mask impl bits", q, 32'h2B);
    lw(12'h104, 32'hFFFF_FFFF);
    lr(12'h104, q); expect32("R6 in mask impl bits", q, 32'h1BB);
    lw(12'h034, 32'h0);
    hr(12'h034, q); expect32("R9 local cannot write out mask", q, 32'h2B);
    hw(12'h050, 32'hCAFE_0001);
    lw(12'h050, 32'h0000_1234);
    lr(12'h050, q); expect32("R9 local cannot write in msg", q, 32'hCAFE_0001);
    hw(12'h068, 32'h2);
    hr(12'h068, q); expect32("R9 host read of in db is zero", q, 0);
    lr(12'h068, q); expect32("R9 in db not cleared by host", q, 32'h2);
    lr(12'h200, q); expect32("R9 unmapped read", q, 0);
    hr(12'h100, q); expect32("R9 host read of in status is zero", q, 0);
  endtask

  initial begin
    rstN = 0; hReq = 0; hWr = 0; lReq = 0; lWr = 0;
    hAddr = 0; lAddr = 0; hWdata = 0; lWdata = 0;
    outPostNe = 0; inPostNe = 0; inPostOvf = 0; inFreeOvf = 0;
    idle(3);
    rstN = 1;
    idle(1);
    t_reset();
    t_messages();
    t_doorbells();
    t_status_race();
    t_irq();
    t_queue();
    t_masks_access();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule